// File: doc/BRIEF.md
# Four-Channel Wiper and Stored-Setting Register Bank

This block keeps the digital state of four potentiometer channels. Each channel has a live 8-bit wiper register and four stored 8-bit setting slots. The wiper register sets the tap position. The slots stand in for non-volatile cells: they have no reset, so their contents survive `rst_n`. A command decoder sends one request per cycle on a flat request bus. The block carries out each request: it reads or writes a wiper, reads a slot, steps a wiper, copies a slot into a wiper, or writes a slot. A copy or slot write can target one channel or all four channels at once.

Any change to the slots is held in a pending stage. It is stored only when chip select is released (`cs_n` rises) after the request. A timed store interval follows. While it runs, the block raises `wip` and refuses further slot changes. Write protect blocks slot changes only. Each wiper is decoded into a one-hot tap select of 256 lines.

Request opcodes on `req_op`: 0 none, 1 read wiper, 2 write wiper, 3 read slot, 4 write slot, 5 copy slot to wiper, 6 copy wiper to slot, 7 step wiper.

Top module: `wiper_reg_bank`

## Requirements
- R1: The first clock edge after the internal reset is released loads every wiper from its own slot 0. Slot contents are not changed by `rst_n`. During and right after reset, `wip` and `rd_valid` are 0.
- R2: For each channel, exactly one of its 256 `tap_sel` lines is high: line `c*256 + wiper`. Value 00h selects line 0 (low end) and FFh selects line 255 (high end).
- R3: Opcode 2 loads `req_data` into the wiper of `req_chan` at the accepting edge. Opcodes 1 and 3 return the wiper or the slot `req_reg` on `rd_data`, with `rd_valid` high for one cycle, one cycle after the request.
- R4: Opcode 4 writes `req_data` into slot `req_reg` of `req_chan`, but only at the first clock edge that sees `cs_n` high after it was low. Until that edge, reads return the old value.
- R5: A store starts at the commit edge. `wip` then stays high for exactly `STORE_CYCLES` cycles.
- R6: Opcode 5 with `req_all`=0 copies slot `req_reg` into the wiper of `req_chan` at once, with no store. Opcode 6 with `req_all`=0 copies that wiper into slot `req_reg`, committed as in R4.
- R7: With `req_all`=1, opcode 5 loads all four wipers from their own slot `req_reg`. Opcode 6 stores all four wipers into their own slot `req_reg` in a single store.
- R8: While `wp_n` is 0, opcodes 4 and 6 are discarded and a later `cs_n` rise starts no store. Wiper writes, copies and steps still act.
- R9: Opcode 7 with `req_data[0]`=1 moves the wiper up one step, and with 0 moves it down one step. It holds at FFh and at 00h; there is no wraparound.
- R10: While `wip` is high, opcodes 4 and 6 are discarded and start no later store. Reads and wiper operations proceed, and slot reads return the newly stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; a rising edge commits a pending slot change |
| wp_n | input | 1 | Write protect, active low; blocks slot changes |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Request opcode |
| req_all | input | 1 | Apply a copy to all channels |
| req_chan | input | 2 | Channel index |
| req_reg | input | 2 | Slot index |
| req_data | input | 8 | Write data; bit 0 gives the step direction |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| wip | output | 1 | Store in progress |
| wiper | output | 32 | Wiper values, channel c at bits c*8 +: 8 |
| tap_sel | output | 1024 | One-hot tap selects, channel c at bits c*256 +: 256 |

## Verification
The assertions assume the decoder sends at most one request per cycle. They also assume it holds `cs_n` low while it issues a request that changes a slot. The recall assertion assumes slot 0 holds a defined value when reset ends.

The stimulus drives every input on the falling edge and raises `req_valid` for exactly one cycle per request. It toggles `cs_n` only between requests. It fills slot 0 of every channel through a global store before it relies on any recall.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  typedef enum logic [2:0] {
    OP_NONE          = 3'd0,
    OP_RD_WIPER      = 3'd1,
    OP_WR_WIPER      = 3'd2,
    OP_RD_SLOT       = 3'd3,
    OP_WR_SLOT       = 3'd4,
    OP_SLOT_TO_WIPER = 3'd5,
    OP_WIPER_TO_SLOT = 3'd6,
    OP_STEP          = 3'd7
  } wrb_op_e;

  // Requests that end in a stored slot change
  function automatic logic changes_slot(input wrb_op_e o);
    return (o == OP_WR_SLOT) || (o == OP_WIPER_TO_SLOT);
  endfunction

endpackage

// File: rtl/wrb_store_seq.sv
module wrb_store_seq #(
  parameter int  STORE_CYCLES = 500000,
  localparam int CNT_W = $clog2(STORE_CYCLES + 1),
  localparam int RUN_W = CNT_W + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic arm,
  output logic commit,
  output logic busy
);

  logic             cs_q;
  logic             armed_q, armed_d;
  logic             busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    commit  = cs_n & ~cs_q & armed_q;
    armed_d = armed_q;
    if (commit)   armed_d = 1'b0;
    else if (arm) armed_d = 1'b1;
    busy_d = busy;
    cnt_d  = cnt_q;
    if (commit) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(STORE_CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      armed_q <= 1'b0;
      busy    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cs_q    <= cs_n;
      armed_q <= armed_d;
      busy    <= busy_d;
      cnt_q   <= cnt_d;
    end
  end

  // Checker: length of the current busy run
  logic [RUN_W-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < RUN_W'(STORE_CYCLES))); // R5
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy_run) == RUN_W'(STORE_CYCLES - 1))); // R5
  AST_BUSY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2))); // R4
  AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed_q); // R10

endmodule

// File: rtl/wrb_channel.sv
module wrb_channel #(
  parameter int  W     = 8,
  parameter int  SLOTS = 4,
  localparam int SL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot,
  input  logic               ld_wiper,
  input  logic [W-1:0]       ld_val,
  input  logic               step_en,
  input  logic               step_up,
  input  logic               slot_we,
  input  logic [SL_W-1:0]    slot_idx,
  input  logic [W-1:0]       slot_val,
  output logic [W-1:0]       wiper,
  output logic [SLOTS*W-1:0] slots
);

  logic [W-1:0]       wiper_d;
  logic [SLOTS*W-1:0] slot_q, slot_d;

  always_comb begin
    wiper_d = wiper;
    if (boot)          wiper_d = slot_q[W-1:0];
    else if (ld_wiper) wiper_d = ld_val;
    else if (step_en) begin
      if (step_up) begin
        if (wiper != '1) wiper_d = wiper + 1'b1;
      end else begin
        if (wiper != '0) wiper_d = wiper - 1'b1;
      end
    end
    slot_d = slot_q;
    slot_d[slot_idx*W +: W] = slot_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper <= '0;
    else        wiper <= wiper_d;
  end

  // Stored slots model retained cells: no reset
  always_ff @(posedge clk) begin
    if (slot_we) slot_q <= slot_d;
  end

  assign slots = slot_q;

  AST_BOOT_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    boot |=> (wiper == $past(slot_q[W-1:0]))); // R1
  AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && !boot && !ld_wiper && wiper != '1) |=> (wiper == $past(wiper) + 1'b1)); // R9
  AST_STEP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && !boot && !ld_wiper && wiper == '1) |=> (wiper == '1)); // R9
  AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && !boot && !ld_wiper && wiper == '0) |=> (wiper == '0)); // R9

endmodule

// File: rtl/wrb_tap_decode.sv
module wrb_tap_decode #(
  parameter int  W    = 8,
  localparam int TAPS = 1 << W
) (
  input  logic [W-1:0]    code,
  output logic [TAPS-1:0] taps
);

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign taps[i] = (code == W'(i));
  end

endmodule

// File: rtl/wiper_reg_bank.sv
module wiper_reg_bank
  import wrb_pkg::*;
#(
  parameter int  CHANS        = 4,
  parameter int  W            = 8,
  parameter int  SLOTS        = 4,
  parameter int  STORE_CYCLES = 500000,
  localparam int CH_W = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  wp_n,
  input  logic                  req_valid,
  input  logic [2:0]            req_op,
  input  logic                  req_all,
  input  logic [CH_W-1:0]       req_chan,
  input  logic [SL_W-1:0]       req_reg,
  input  logic [W-1:0]          req_data,
  output logic                  rd_valid,
  output logic [W-1:0]          rd_data,
  output logic                  wip,
  output logic [CHANS*W-1:0]    wiper,
  output logic [CHANS*TAPS-1:0] tap_sel
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic boot_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  wrb_op_e            op;
  logic               go, arm, commit, busy, step_up;
  logic [CHANS-1:0]   chan_hit, ld_wiper, step_en, slot_we;
  logic [W-1:0]       ld_val     [CHANS];
  logic [W-1:0]       wiper_w    [CHANS];
  logic [SLOTS*W-1:0] slot_w     [CHANS];
  logic [CHANS-1:0]   pend_mask_q, pend_mask_d;
  logic [SL_W-1:0]    pend_idx_q;
  logic [W-1:0]       pend_val_q [CHANS];
  logic [W-1:0]       pend_val_d [CHANS];
  logic               rd_go;
  logic [W-1:0]       rd_pick;

  always_comb begin
    op          = wrb_op_e'(req_op);
    go          = req_valid & ~boot_q;
    step_up     = req_data[0];
    arm         = go & changes_slot(op) & wp_n & ~busy;
    pend_mask_d = pend_mask_q;
    for (int c = 0; c < CHANS; c++) begin
      ld_wiper[c]   = go & (((op == OP_WR_WIPER) & chan_hit[c]) |
                            ((op == OP_SLOT_TO_WIPER) & (req_all | chan_hit[c])));
      ld_val[c]     = (op == OP_WR_WIPER) ? req_data : slot_w[c][req_reg*W +: W];
      step_en[c]    = go & (op == OP_STEP) & chan_hit[c];
      slot_we[c]    = commit & pend_mask_q[c];
      pend_val_d[c] = (op == OP_WR_SLOT) ? req_data : wiper_w[c];
      if (arm) pend_mask_d[c] = (op == OP_WR_SLOT) ? chan_hit[c] : (req_all | chan_hit[c]);
    end
    rd_go   = go & ((op == OP_RD_WIPER) | (op == OP_RD_SLOT));
    rd_pick = (op == OP_RD_WIPER) ? wiper_w[req_chan] : slot_w[req_chan][req_reg*W +: W];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_mask_q <= '0;
      rd_valid    <= 1'b0;
    end else begin
      pend_mask_q <= pend_mask_d;
      rd_valid    <= rd_go;
    end
  end

  always_ff @(posedge clk) begin
    if (arm) begin
      pend_idx_q <= req_reg;
      for (int c = 0; c < CHANS; c++) pend_val_q[c] <= pend_val_d[c];
    end
    if (rd_go) rd_data <= rd_pick;
  end

  wrb_store_seq #(.STORE_CYCLES(STORE_CYCLES)) u_store (
    .clk    (clk),
    .rst_n  (rst_s),
    .cs_n   (cs_n),
    .arm    (arm),
    .commit (commit),
    .busy   (busy)
  );
  assign wip = busy;

  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    assign chan_hit[c] = (req_chan == CH_W'(c));

    wrb_channel #(.W(W), .SLOTS(SLOTS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_s),
      .boot     (boot_q),
      .ld_wiper (ld_wiper[c]),
      .ld_val   (ld_val[c]),
      .step_en  (step_en[c]),
      .step_up  (step_up),
      .slot_we  (slot_we[c]),
      .slot_idx (pend_idx_q),
      .slot_val (pend_val_q[c]),
      .wiper    (wiper_w[c]),
      .slots    (slot_w[c])
    );

    wrb_tap_decode #(.W(W)) u_dec (
      .code (wiper_w[c]),
      .taps (tap_sel[c*TAPS +: TAPS])
    );

    assign wiper[c*W +: W] = wiper_w[c];

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
      $onehot(tap_sel[c*TAPS +: TAPS])); // R2
    AST_COPY_ONE: assert property (@(posedge clk) disable iff (!rst_s)
      (go && op == OP_SLOT_TO_WIPER && !req_all && chan_hit[c]) |=>
        (wiper_w[c] == $past(slot_w[c][req_reg*W +: W]))); // R6
    AST_COPY_ALL: assert property (@(posedge clk) disable iff (!rst_s)
      (go && op == OP_SLOT_TO_WIPER && req_all) |=>
        (wiper_w[c] == $past(slot_w[c][req_reg*W +: W]))); // R7
    AST_STORE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_s)
      slot_we[c] |-> (cs_n && !$past(cs_n))); // R4
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> $past(req_valid)); // R3
  AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_s)
    (go && changes_slot(op) && !wp_n) |=> $stable(pend_mask_q)); // R8
  AST_BUSY_GUARD: assert property (@(posedge clk) disable iff (!rst_s)
    (go && changes_slot(op) && busy) |=> $stable(pend_mask_q)); // R10

endmodule

// File: tb/wiper_reg_bank_tb.sv
module wiper_reg_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STORE      = 12;
  localparam int WDOG       = 20000;

  logic         clk, rst_n, cs_n, wp_n, req_valid, req_all;
  logic [2:0]   req_op;
  logic [1:0]   req_chan, req_reg;
  logic [7:0]   req_data;
  logic         rd_valid, wip;
  logic [7:0]   rd_data;
  logic [31:0]  wiper;
  logic [1023:0] tap_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  wiper_reg_bank #(.STORE_CYCLES(STORE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .req_valid(req_valid),
    .req_op(req_op), .req_all(req_all), .req_chan(req_chan), .req_reg(req_reg),
    .req_data(req_data), .rd_valid(rd_valid), .rd_data(rd_data), .wip(wip),
    .wiper(wiper), .tap_sel(tap_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {opcode, channel, data, expected wiper of that channel}
  localparam logic [20:0] VEC [12] = '{
    {3'd2, 2'd1, 8'h80, 8'h80},
    {3'd7, 2'd1, 8'h01, 8'h81},
    {3'd7, 2'd1, 8'h00, 8'h80},
    {3'd2, 2'd1, 8'hFE, 8'hFE},
    {3'd7, 2'd1, 8'h01, 8'hFF},
    {3'd7, 2'd1, 8'h01, 8'hFF},
    {3'd2, 2'd2, 8'h01, 8'h01},
    {3'd7, 2'd2, 8'h00, 8'h00},
    {3'd7, 2'd2, 8'h00, 8'h00},
    {3'd7, 2'd2, 8'h01, 8'h01},
    {3'd2, 2'd3, 8'h00, 8'h00},
    {3'd2, 2'd0, 8'hFF, 8'hFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic all, input logic [1:0] ch,
                        input logic [1:0] rg, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_all = all; req_chan = ch; req_reg = rg; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0; req_all = 1'b0;
  endtask

  task automatic rd_slot(input logic [1:0] ch, input logic [1:0] rg, output logic [7:0] v);
    do_req(3'd3, 1'b0, ch, rg, 8'h00);
    v = rd_valid ? rd_data : 8'hxx;
  endtask

  task automatic cs_rise();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (wip) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; req_valid = 1'b0;
    req_op = 3'd0; req_all = 1'b0; req_chan = 2'd0; req_reg = 2'd0; req_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 wip after reset", wip, 0);
    chk("R1 rd_valid after reset", rd_valid, 0);
    cs_n = 1'b0;

    // Global store of all wipers into slot 0
    for (int c = 0; c < 4; c++) do_req(3'd2, 1'b0, 2'(c), 2'd0, 8'(8'h21 * (c + 1)));
    do_req(3'd6, 1'b1, 2'd0, 2'd0, 8'h00);
    cs_rise();
    wait_idle(n);
    chk("R5 store length", n, STORE);
    for (int c = 0; c < 4; c++) begin
      rd_slot(2'(c), 2'd0, v);
      chk("R7 global store slot0", v, 8'h21 * (c + 1));
    end

    // Vector table: wiper writes and steps
    for (int i = 0; i < 12; i++) begin
      logic [20:0] e;
      int ch;
      e  = VEC[i];
      ch = int'(e[17:16]);
      do_req(e[20:18], 1'b0, e[17:16], 2'd0, e[15:8]);
      chk("R9 R3 wiper value", wiper[ch*8 +: 8], e[7:0]);
      chk("R2 tap line", tap_sel[ch*256 + int'(e[7:0])], 1);
      chk("R2 tap count", $countones(tap_sel[ch*256 +: 256]), 1);
    end
    do_req(3'd1, 1'b0, 2'd1, 2'd0, 8'h00);
    chk("R3 read wiper valid", rd_valid, 1);
    chk("R3 read wiper data", rd_data, 8'hFF);
    @(negedge clk);
    chk("R3 read valid one cycle", rd_valid, 0);

    // Global copy slot 0 into all wipers
    do_req(3'd5, 1'b1, 2'd0, 2'd0, 8'h00);
    for (int c = 0; c < 4; c++) chk("R7 global recall", wiper[c*8 +: 8], 8'h21 * (c + 1));

    // Single-channel copies
    do_req(3'd2, 1'b0, 2'd0, 2'd0, 8'h05);
    do_req(3'd5, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R6 slot to wiper", wiper[7:0], 8'h21);
    chk("R6 copy needs no store", wip, 0);
    chk("R6 other channel kept", wiper[15:8], 8'h42);
    do_req(3'd6, 1'b0, 2'd3, 2'd2, 8'h00);
    cs_rise();
    wait_idle(n);
    rd_slot(2'd3, 2'd2, v);
    chk("R6 wiper to slot", v, 8'h84);

    // Deferred commit and busy interval
    do_req(3'd4, 1'b0, 2'd1, 2'd3, 8'h11);
    cs_rise();
    wait_idle(n);
    do_req(3'd4, 1'b0, 2'd1, 2'd3, 8'hA5);
    rd_slot(2'd1, 2'd3, v);
    chk("R4 old value before release", v, 8'h11);
    cs_rise();
    chk("R4 store started on release", wip, 1);
    rd_slot(2'd1, 2'd3, v);
    chk("R10 read during store", v, 8'hA5);
    do_req(3'd4, 1'b0, 2'd1, 2'd3, 8'h5A);
    do_req(3'd2, 1'b0, 2'd1, 2'd0, 8'h33);
    chk("R10 wiper write during store", wiper[15:8], 8'h33);
    wait_idle(n);
    cs_rise();
    chk("R10 ignored request starts no store", wip, 0);
    rd_slot(2'd1, 2'd3, v);
    chk("R10 ignored request kept value", v, 8'hA5);

    // Write protect
    wp_n = 1'b0;
    do_req(3'd4, 1'b0, 2'd2, 2'd0, 8'h77);
    do_req(3'd2, 1'b0, 2'd2, 2'd0, 8'h44);
    chk("R8 wiper write under protect", wiper[23:16], 8'h44);
    do_req(3'd6, 1'b1, 2'd0, 2'd0, 8'h00);
    cs_rise();
    chk("R8 no store under protect", wip, 0);
    rd_slot(2'd2, 2'd0, v);
    chk("R8 slot unchanged", v, 8'h63);
    wp_n = 1'b1;

    // Reset: recall slot 0, slots retained
    @(negedge clk); rst_n = 1'b0; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b0;
    for (int c = 0; c < 4; c++) chk("R1 recall slot0", wiper[c*8 +: 8], 8'h21 * (c + 1));
    chk("R1 wip after second reset", wip, 0);
    rd_slot(2'd1, 2'd3, v);
    chk("R1 slot retained", v, 8'hA5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule